// File: doc/BRIEF.md
# Flash Write-Completion Status Poller

This block sits on the host side of a parallel NOR flash. Another block sends the program or erase command. This block then works out when the internal write has finished. It reads a single target location again and again over a simple request/acknowledge read port, and judges each returned word by one of two methods. The `mode` input chooses the method:

- **Complement polling:** watch the top bit of the low byte.
- **Toggle polling:** watch whether bit 6 stops changing between back-to-back reads.

The status bits and the array finishing can come out of step, so a word can look finished while the full data still differs from what was written. In that case the poller does not reject the write at once. It reads the location twice more and decides from those two reads. A programmable limit on the number of status reads bounds the wait, and reaching it reports a timeout. Each job ends with a one-cycle `done` pulse together with a pass flag or a timeout flag.

Top module: `flash_status_poller`

## Requirements
- R1: After synchronous reset, `rd_req`, `done`, `pass` and `timeout` are all 0.
- R2: When idle, a `start` pulse latches `mode`, `exp_data`, `tgt_addr` and `max_polls`, and clears `pass` and `timeout`. A `start` that arrives while a job is running is ignored: that job's reads, result and count stay unchanged.
- R3: Every read is a one-cycle `rd_req` with `rd_addr` equal to the latched target address. No new request is issued until `rd_ack` has returned the word for the previous one.
- R4: With `mode`=0 (complement polling), a status read shows completion when bit 7 of the returned word equals bit 7 of `exp_data`. For an erase, `exp_data` is all ones.
- R5: With `mode`=1 (toggle polling), a status read shows completion when its bit 6 equals bit 6 of the status read just before it. The first read of a job never shows completion.
- R6: A status read that shows completion and whose whole word equals `exp_data` ends the job with `pass`=1. No further read is made.
- R7: A status read that shows completion but whose word differs from `exp_data` is followed by exactly two confirmation reads of the same location. `pass` is 1 only if both of those words equal `exp_data`; otherwise the job ends with `pass`=0 and `timeout`=0.
- R8: Call a status read that does not show completion inconclusive. When the n-th inconclusive read gives n >= `max_polls`, the job ends with `timeout`=1 and `pass`=0. So exactly `max_polls` status reads are made, and at least one.
- R9: `done` is a one-cycle pulse in the cycle after the `rd_ack` that decides the job. `pass` and `timeout` keep their values until the next accepted `start`. They are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a poll job (accepted only when idle) |
| mode | input | 1 | 0 = complement polling on bit 7, 1 = toggle polling on bit 6 |
| exp_data | input | DATA_W | Word expected at the location once the write has finished |
| tgt_addr | input | ADDR_W | Location to poll |
| max_polls | input | CNT_W | Upper bound on status reads |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | DATA_W | Word returned with `rd_ack` |
| done | output | 1 | One-cycle end-of-job pulse |
| pass | output | 1 | Write confirmed complete and correct |
| timeout | output | 1 | Poll limit reached without completion |

## Verification
The assertions assume a well-behaved read port:

- `rd_ack` is a single-cycle pulse.
- `rd_ack` arrives only while a request is outstanding, and never in the same cycle as `rd_req`.
- `start` is a single-cycle pulse.

The bench's flash model keeps to these rules. It answers each request after a fixed latency of at least one idle cycle, returns one scripted word per request, and drives every input on the falling edge. The only `start` pulses it sends while a job is active are deliberate ones, and the assertions allow for them.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_CREQ,
        ST_CWAIT
    } fsp_state_e;

    typedef enum logic {
        POLL_DQ7 = 1'b0,
        POLL_DQ6 = 1'b1
    } fsp_mode_e;

    localparam int COMPL_BIT  = 7;
    localparam int TOGGLE_BIT = 6;
    localparam int CONF_READS = 2;

    typedef struct packed {
        logic settled;   // status bits say the write is over
        logic match;     // whole word equals the expected word
    } fsp_verdict_t;

    function automatic logic compl_settled(logic rd_bit, logic exp_bit);
        return rd_bit == exp_bit;
    endfunction

    function automatic logic toggle_settled(logic have_prev, logic prev_bit, logic rd_bit);
        return have_prev && (prev_bit == rd_bit);
    endfunction

endpackage

// File: rtl/fsp_judge.sv
module fsp_judge
    import fsp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  fsp_mode_e           mode,
    input  logic [DATA_W-1:0]   exp_word,
    input  logic [DATA_W-1:0]   rd_word,
    input  logic                have_prev,
    input  logic                prev_tog,
    output fsp_verdict_t        verdict
);
    always_comb begin
        verdict.match = (rd_word == exp_word);
        unique case (mode)
            POLL_DQ7: verdict.settled = compl_settled(rd_word[COMPL_BIT], exp_word[COMPL_BIT]);
            POLL_DQ6: verdict.settled = toggle_settled(have_prev, prev_tog, rd_word[TOGGLE_BIT]);
            default:  verdict.settled = 1'b0;
        endcase
    end
endmodule

// File: rtl/fsp_poll_ctr.sv
module fsp_poll_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    localparam int W = CNT_W + 1;

    logic [W-1:0] cnt_q;

    // the read being judged now is number cnt_q+1
    assign last = (cnt_q + W'(1)) >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
    import fsp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode,
    input  logic [DATA_W-1:0] exp_data,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [CNT_W-1:0]  max_polls,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              pass,
    output logic              timeout
);
    localparam int CIDX_W = $clog2(CONF_READS);

    fsp_state_e        state_q;
    fsp_mode_e         mode_q;
    logic [DATA_W-1:0] exp_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  max_q;
    logic              have_prev_q;
    logic              prev_tog_q;
    logic [CIDX_W-1:0] conf_idx_q;
    logic              conf_ok_q;

    fsp_verdict_t      verdict;
    logic              ctr_clr;
    logic              ctr_inc;
    logic              ctr_last;
    logic              accept;

    assign accept  = (state_q == ST_IDLE) && start;
    assign rd_req  = (state_q == ST_REQ) || (state_q == ST_CREQ);
    assign rd_addr = addr_q;
    assign ctr_clr = accept;
    assign ctr_inc = (state_q == ST_WAIT) && rd_ack && !verdict.settled;

    fsp_judge #(.DATA_W(DATA_W)) judge_i (
        .mode      (mode_q),
        .exp_word  (exp_q),
        .rd_word   (rd_data),
        .have_prev (have_prev_q),
        .prev_tog  (prev_tog_q),
        .verdict   (verdict)
    );

    fsp_poll_ctr #(.CNT_W(CNT_W)) ctr_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (ctr_clr),
        .inc   (ctr_inc),
        .limit (max_q),
        .last  (ctr_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            mode_q      <= POLL_DQ7;
            exp_q       <= '0;
            addr_q      <= '0;
            max_q       <= '0;
            have_prev_q <= 1'b0;
            prev_tog_q  <= 1'b0;
            conf_idx_q  <= '0;
            conf_ok_q   <= 1'b0;
            done        <= 1'b0;
            pass        <= 1'b0;
            timeout     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q      <= fsp_mode_e'(mode);
                        exp_q       <= exp_data;
                        addr_q      <= tgt_addr;
                        max_q       <= max_polls;
                        have_prev_q <= 1'b0;
                        pass        <= 1'b0;
                        timeout     <= 1'b0;
                        state_q     <= ST_REQ;
                    end
                end
                ST_REQ:  state_q <= ST_WAIT;
                ST_CREQ: state_q <= ST_CWAIT;
                ST_WAIT: begin
                    if (rd_ack) begin
                        if (verdict.settled && verdict.match) begin
                            done    <= 1'b1;
                            pass    <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (verdict.settled) begin
                            conf_idx_q <= '0;
                            conf_ok_q  <= 1'b1;
                            state_q    <= ST_CREQ;
                        end else if (ctr_last) begin
                            done    <= 1'b1;
                            timeout <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            have_prev_q <= 1'b1;
                            prev_tog_q  <= rd_data[TOGGLE_BIT];
                            state_q     <= ST_REQ;
                        end
                    end
                end
                ST_CWAIT: begin
                    if (rd_ack) begin
                        if (conf_idx_q == CIDX_W'(CONF_READS - 1)) begin
                            done    <= 1'b1;
                            pass    <= conf_ok_q && verdict.match;
                            state_q <= ST_IDLE;
                        end else begin
                            conf_ok_q  <= conf_ok_q && verdict.match;
                            conf_idx_q <= conf_idx_q + CIDX_W'(1);
                            state_q    <= ST_CREQ;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker (
    input logic clk,
    input logic rst,
    input logic start,
    input logic rd_req,
    input logic rd_ack,
    input logic done,
    input logic pass,
    input logic timeout
);
    logic outstanding_q;

    always_ff @(posedge clk) begin
        if (rst) outstanding_q <= 1'b0;
        else if (rd_req) outstanding_q <= 1'b1;
        else if (rd_ack) outstanding_q <= 1'b0;
    end

    p_req_single_r3: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    p_wait_for_ack_r3: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> !outstanding_q);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_ack_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(rd_ack));

    p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(pass && timeout));

    p_flags_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !start |=> (($stable(pass) && $stable(timeout)) || done));

    p_no_req_with_done_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !rd_req);
endmodule

bind flash_status_poller fsp_checker chk_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .rd_req  (rd_req),
    .rd_ack  (rd_ack),
    .done    (done),
    .pass    (pass),
    .timeout (timeout)
);

// File: tb/flash_status_poller_tb_top.sv
module flash_status_poller_tb_top;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 20;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic              start;
    logic              mode;
    logic [DATA_W-1:0] exp_data;
    logic [ADDR_W-1:0] tgt_addr;
    logic [CNT_W-1:0]  max_polls;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_ack;
    logic [DATA_W-1:0] rd_data;
    logic              done;
    logic              pass;
    logic              timeout;

    always #4 clk = ~clk;   // 125 MHz

    flash_status_poller #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .exp_data(exp_data),
        .tgt_addr(tgt_addr), .max_polls(max_polls), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .done(done), .pass(pass), .timeout(timeout)
    );

    typedef struct {
        logic   pass;
        logic   tmo;
        int     reads;
        string  tag;
    } exp_t;

    exp_t              exp_q[$];
    logic [DATA_W-1:0] resp_q[$];
    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int reads  = 0;
    int last_ack_cyc = -10;
    int done_seen = 0;
    int lat = 1;
    logic [ADDR_W-1:0] cur_addr;
    logic finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // flash model: answers each request after lat cycles
    initial begin
        rd_ack  = 1'b0;
        rd_data = '0;
        forever begin
            @(negedge clk);
            rd_ack = 1'b0;
            if (rd_req) begin
                check(rd_addr == cur_addr, "R3", "rd_addr", rd_addr, cur_addr);
                reads++;
                repeat (lat) @(negedge clk);
                rd_data = (resp_q.size() > 0) ? resp_q.pop_front() : 16'h0080;
                rd_ack = 1'b1;
                last_ack_cyc = cyc;
            end
        end
    end

    // monitor: pops the scoreboard on each done pulse
    initial begin
        forever begin
            @(negedge clk);
            if (done && !rst) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected done", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(pass == e.pass, e.tag, "pass", pass, e.pass);
                    check(timeout == e.tmo, e.tag, "timeout", timeout, e.tmo);
                    check(reads == e.reads, e.tag, "read count", reads, e.reads);
                    check(cyc == last_ack_cyc + 1, "R9", "done one cycle after ack",
                          cyc, last_ack_cyc + 1);
                end
                @(negedge clk);
                check(!done, "R9", "done width", done, 0);
                done_seen++;
            end
        end
    end

    task automatic run_case(input logic m, input logic [DATA_W-1:0] ev,
                            input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] mx,
                            input int l, input logic ep, input logic et,
                            input int er, input string tag, input bit poke);
        exp_t e;
        int target;
        e.pass = ep; e.tmo = et; e.reads = er; e.tag = tag;
        exp_q.push_back(e);
        target = done_seen + 1;
        lat = l;
        reads = 0;
        cur_addr = a;
        @(negedge clk);
        mode = m; exp_data = ev; tgt_addr = a; max_polls = mx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R2: a second start mid-job with different settings must be ignored
            repeat (3) @(negedge clk);
            mode = ~m; exp_data = ~ev; tgt_addr = ~a; max_polls = 1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_seen < target) @(negedge clk);
        repeat (3) @(negedge clk);
        check(pass == ep, "R9", "pass held", pass, ep);
        check(timeout == et, "R9", "timeout held", timeout, et);
        check(resp_q.size() == 0, tag, "unused responses", resp_q.size(), 0);
        resp_q.delete();
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; mode = 1'b0; exp_data = '0; tgt_addr = '0; max_polls = '0;
        cur_addr = '0;
        repeat (3) @(negedge clk);
        check(rd_req == 1'b0, "R1", "rd_req at reset", rd_req, 0);
        check(done == 1'b0, "R1", "done at reset", done, 0);
        check(pass == 1'b0, "R1", "pass at reset", pass, 0);
        check(timeout == 1'b0, "R1", "timeout at reset", timeout, 0);
        rst = 1'b0;

        // R4 program: bit7 complemented until done
        resp_q = '{16'h0080, 16'h0080, 16'h1234};
        run_case(1'b0, 16'h1234, 20'h00555, 16'd10, 1, 1'b1, 1'b0, 3, "R4", 1'b0);
        // R4 erase with all ones expected
        resp_q = '{16'h0000, 16'hFFFF};
        run_case(1'b0, 16'hFFFF, 20'h3A000, 16'd10, 2, 1'b1, 1'b0, 2, "R4", 1'b0);
        // R7 conflict then two good confirmations
        resp_q = '{16'h0034, 16'h1234, 16'h1234};
        run_case(1'b0, 16'h1234, 20'h00100, 16'd10, 1, 1'b1, 1'b0, 3, "R7", 1'b0);
        // R7 conflict then one bad confirmation
        resp_q = '{16'h0034, 16'h1234, 16'h0034};
        run_case(1'b0, 16'h1234, 20'h00100, 16'd10, 3, 1'b0, 1'b0, 3, "R7", 1'b0);
        // R5 toggling then steady, R6 no extra read
        resp_q = '{16'h0040, 16'h0000, 16'h0040, 16'h0000, 16'hABCD, 16'hABCD};
        run_case(1'b1, 16'hABCD, 20'h7FFFF, 16'd20, 1, 1'b1, 1'b0, 6, "R5", 1'b0);
        // R5 + R7 steady but mismatched word, confirmed good
        resp_q = '{16'h0000, 16'h0040, 16'h0040, 16'hABCD, 16'hABCD};
        run_case(1'b1, 16'hABCD, 20'h01234, 16'd20, 2, 1'b1, 1'b0, 5, "R7", 1'b0);
        // R7 toggle mode, confirmation fails on first re-read
        resp_q = '{16'h0000, 16'h0000, 16'h0000, 16'h1111};
        run_case(1'b1, 16'h1111, 20'h01234, 16'd20, 1, 1'b0, 1'b0, 4, "R7", 1'b0);
        // R8 timeouts in both modes and with a zero limit
        resp_q = '{16'h0080, 16'h0080, 16'h0080, 16'h0080};
        run_case(1'b0, 16'h0000, 20'h00002, 16'd4, 1, 1'b0, 1'b1, 4, "R8", 1'b0);
        resp_q = '{16'h0040, 16'h0000, 16'h0040};
        run_case(1'b1, 16'h0000, 20'h00003, 16'd3, 2, 1'b0, 1'b1, 3, "R8", 1'b0);
        resp_q = '{16'h0080};
        run_case(1'b0, 16'h0000, 20'h00004, 16'd0, 1, 1'b0, 1'b1, 1, "R8", 1'b0);
        // R2 start during a job is ignored
        resp_q = '{16'h0080, 16'h0080, 16'h0080, 16'h5A5A};
        run_case(1'b0, 16'h5A5A, 20'h0BEEF, 16'd10, 2, 1'b1, 1'b0, 4, "R2", 1'b1);
        // R6 immediate pass on first read
        resp_q = '{16'h00C3};
        run_case(1'b0, 16'h00C3, 20'h00010, 16'd5, 1, 1'b1, 1'b0, 1, "R6", 1'b0);

        check(exp_q.size() == 0, "R9", "pending results", exp_q.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "R9", "watchdog expired", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule